// File: doc/BRIEF.md
# Exported Object Access Responder

This block lives inside a user FPGA design and services access requests that a host kernel sends over a message link. Each request names one exported hardware object and carries a command, an offset and a byte length. The exported objects are a bank of single-word control registers, an on-chip byte-addressable memory, a read-only status word, a FIFO that carries bytes toward the host, and a FIFO that carries bytes from the host.

Every request gets an acknowledge. The acknowledge holds a signed count of the bytes that moved, or -1 when the request is illegal. Reads return their data right after the acknowledge. The block keeps no cache, so every access acts on the live hardware object. The rest of the user logic sees the registers, the memory, the ready flag and both FIFOs through plain hardware-side ports.

Requests and responses travel as 32-bit valid/ready word streams. The block handles only one request at a time.

Top module: `obj_access_responder`

## Requirements
- R1: A request starts with two words. Word 0 holds the command in bits 31:24 (0x01 read, 0x02 write), the object identifier in bits 23:16 and the byte length in bits 15:0. Word 1 is the byte offset. A write is followed by ceil(length/4) data words, and payload byte k sits in bits 8*(k mod 4)+7 : 8*(k mod 4) of word k/4 (little-endian).
- R2: Each request is answered by a two-word acknowledge. Word 0 is {code, identifier, 16'h0}, with code 0x81 for a read, 0x82 for a write and 0xFF for any other command. Word 1 is the signed byte count. After a read acknowledge come ceil(count/4) little-endian data words, with unused upper bytes set to zero. An unknown command takes up only the two header words and returns count -1.
- R3: Register identifiers 0..NUM_REGS-1 each name one 4-byte read/write register, which is driven on reg_o. An access with offset not 0 or length not 4 returns -1 and leaves the register unchanged.
- R4: Identifier 0x10 names a MEM_BYTES-byte memory that can be read and written at any byte offset and length within its bounds. The hardware port reads it as little-endian words.
- R5: A memory access where offset plus length exceeds MEM_BYTES returns -1 and leaves the memory unchanged. Its write data words are still consumed.
- R6: Identifier 0x20 is the to-host FIFO. A read returns min(length, occupancy) bytes in push order. A read of an empty FIFO returns count 0 and no data words.
- R7: Identifier 0x21 is the from-host FIFO. A write stores min(length, free space) bytes, returns that count and drops the rest. The hardware pops the bytes in order.
- R8: A request for an unknown identifier, for a direction the object forbids (writing 0x20 or 0x30, reading 0x21) or to a FIFO at a nonzero offset returns -1. Its write data words are consumed.
- R9: Identifier 0x30 is a read-only 4-byte status word. Bit 0 carries mem_ready_i and the other bits read as zero.
- R10: No result is cached. Each read reflects the object's state at the time of that request.
- R11: req_ready_o is low whenever rsp_valid_o is high. A new request word is taken only after the last response word of the current request has been sent.
- R12: A hardware push into the to-host FIFO in the same cycle as a host read pop takes effect even when the FIFO was full. A push into a full FIFO with no pop in that cycle is dropped.
- R13: After reset, req_ready_o=1, rsp_valid_o=0, reg_o=0, to-host full is 0 and from-host empty is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request word valid |
| req_ready_o | output | 1 | Request word accepted |
| req_data_i | input | 32 | Request word |
| rsp_valid_o | output | 1 | Response word valid |
| rsp_ready_i | input | 1 | Response word taken |
| rsp_data_o | output | 32 | Response word |
| reg_o | output | 32*NUM_REGS | Register bank contents, register r in bits 32r+31:32r |
| mem_ready_i | input | 1 | Memory-contents-valid flag shown by the status object |
| hw_mem_addr_i | input | log2(MEM_BYTES/4) | Hardware word address into the memory |
| hw_mem_rdata_o | output | 32 | Memory word at hw_mem_addr_i |
| toh_push_i | input | 1 | Hardware push into the to-host FIFO |
| toh_data_i | input | 8 | Byte pushed toward the host |
| toh_full_o | output | 1 | To-host FIFO full |
| frh_pop_i | input | 1 | Hardware pop from the from-host FIFO |
| frh_data_o | output | 8 | Head byte of the from-host FIFO |
| frh_empty_o | output | 1 | From-host FIFO empty |

## Verification
The to-host FIFO can see a hardware push and a host pop in the same clock. The bench fills that FIFO, then holds a hardware push asserted for the whole of a host read. Only the push in the pop cycle can land, because every earlier push meets a full FIFO and is dropped. A second read must then return the remaining old bytes followed by exactly one pushed byte, and before that the byte pushed while the FIFO was full must not appear.

// File: rtl/obj_resp_pkg.sv
package obj_resp_pkg;
  localparam int LANES = 4;

  localparam logic [7:0] CMD_RD  = 8'h01;
  localparam logic [7:0] CMD_WR  = 8'h02;
  localparam logic [7:0] ACK_RD  = 8'h81;
  localparam logic [7:0] ACK_WR  = 8'h82;
  localparam logic [7:0] ACK_BAD = 8'hFF;

  typedef enum logic [2:0] {
    S_HDR, S_OFF, S_WDAT, S_ACK0, S_ACK1, S_RDAT
  } state_e;

  typedef enum logic [2:0] {
    K_NONE, K_REG, K_MEM, K_TOH, K_FRH, K_RDY
  } kind_e;
endpackage

// File: rtl/ora_fifo.sv
module ora_fifo #(
  parameter int DEPTH     = 16,
  parameter int IN_LANES  = 1,
  parameter int OUT_LANES = 4,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int IN_NW  = $clog2(IN_LANES + 1),
  localparam int OUT_NW = $clog2(OUT_LANES + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [IN_NW-1:0]       push_n_i,
  input  logic [8*IN_LANES-1:0]  wdata_i,
  input  logic [OUT_NW-1:0]      pop_n_i,
  output logic [8*OUT_LANES-1:0] rdata_o,
  output logic [CNT_W-1:0]       count_o
);
  logic [7:0]       mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_q + PTR_W'(push_n_i);
      rp_q  <= rp_q + PTR_W'(pop_n_i);
      cnt_q <= cnt_q + CNT_W'(push_n_i) - CNT_W'(pop_n_i);
    end
  end

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < IN_LANES; k++) begin
      if (k < int'(push_n_i)) mem_q[wp_q + PTR_W'(k)] <= wdata_i[8*k +: 8];
    end
  end

  for (genvar k = 0; k < OUT_LANES; k++) begin : g_rd
    assign rdata_o[8*k +: 8] = mem_q[rp_q + PTR_W'(k)];
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/ora_store.sv
module ora_store #(
  parameter int NUM_REGS  = 4,
  parameter int MEM_BYTES = 256,
  localparam int REG_BYTES = 4 * NUM_REGS,
  localparam int TOT       = REG_BYTES + MEM_BYTES,
  localparam int AW        = $clog2(TOT),
  localparam int MEM_AW    = $clog2(MEM_BYTES / 4)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [31:0]           addr_i,
  input  logic [3:0]            we_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           rdata_o,
  input  logic [MEM_AW-1:0]     hw_addr_i,
  output logic [31:0]           hw_rdata_o,
  output logic [32*NUM_REGS-1:0] reg_o
);
  // registers occupy bytes 0..REG_BYTES-1, memory follows
  logic [7:0] bytes_q [TOT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TOT; i++) bytes_q[i] <= 8'h00;
    end else begin
      for (int k = 0; k < 4; k++) begin
        if (we_i[k] && ((addr_i + 32'(k)) < 32'(TOT)))
          bytes_q[AW'(addr_i + 32'(k))] <= wdata_i[8*k +: 8];
      end
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic [31:0] lane_a;
    assign lane_a = addr_i + 32'(k);
    assign rdata_o[8*k +: 8] = (lane_a < 32'(TOT)) ? bytes_q[lane_a[AW-1:0]] : 8'h00;
    assign hw_rdata_o[8*k +: 8] =
      bytes_q[AW'(REG_BYTES) + AW'({hw_addr_i, 2'b00}) + AW'(k)];
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    for (genvar b = 0; b < 4; b++) begin : g_byte
      assign reg_o[32*r + 8*b +: 8] = bytes_q[4*r + b];
    end
  end
endmodule

// File: rtl/ora_ctrl.sv
module ora_ctrl
  import obj_resp_pkg::*;
#(
  parameter int         NUM_REGS   = 4,
  parameter int         MEM_BYTES  = 256,
  parameter int         FIFO_DEPTH = 16,
  parameter logic [7:0] ID_MEM     = 8'h10,
  parameter logic [7:0] ID_TOH     = 8'h20,
  parameter logic [7:0] ID_FRH     = 8'h21,
  parameter logic [7:0] ID_RDY     = 8'h30,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1),
  localparam int REG_BYTES = 4 * NUM_REGS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [31:0]      req_data_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [31:0]      rsp_data_o,
  output logic [31:0]      st_addr_o,
  output logic [3:0]       st_we_o,
  output logic [31:0]      st_wdata_o,
  input  logic [31:0]      st_rdata_i,
  input  logic [CNT_W-1:0] toh_count_i,
  input  logic [31:0]      toh_rdata_i,
  output logic [2:0]       toh_pop_n_o,
  input  logic [CNT_W-1:0] frh_count_i,
  output logic [2:0]       frh_push_n_o,
  output logic [31:0]      frh_wdata_o,
  input  logic             mem_ready_i
);
  state_e      state_q;
  kind_e       kind_q, kind_d;
  logic [7:0]  cmd_q, id_q;
  logic [15:0] len_q, rem_q, words_q;
  logic [31:0] cnt_q, cur_q;

  logic        req_fire, rsp_fire, is_rd, is_wr, legal;
  logic [15:0] xfer, avail, space;
  logic [31:0] base_d;
  logic [16:0] words_d;
  logic [2:0]  n4;
  logic [7:0]  code;
  logic [31:0] src;

  assign req_ready_o = (state_q == S_HDR) || (state_q == S_OFF) || (state_q == S_WDAT);
  assign rsp_valid_o = (state_q == S_ACK0) || (state_q == S_ACK1) || (state_q == S_RDAT);
  assign req_fire    = req_valid_i && req_ready_o;
  assign rsp_fire    = rsp_valid_o && rsp_ready_i;
  assign is_rd       = (cmd_q == CMD_RD);
  assign is_wr       = (cmd_q == CMD_WR);
  assign n4          = (rem_q >= 16'd4) ? 3'd4 : rem_q[2:0];
  assign avail       = 16'(toh_count_i);
  assign space       = 16'(FIFO_DEPTH) - 16'(frh_count_i);
  assign words_d     = (17'(len_q) + 17'd3) >> 2;

  // decode during the offset word; req_data_i is the offset
  always_comb begin
    kind_d = K_NONE;
    if (id_q < 8'(NUM_REGS))  kind_d = K_REG;
    else if (id_q == ID_MEM)  kind_d = K_MEM;
    else if (id_q == ID_TOH)  kind_d = K_TOH;
    else if (id_q == ID_FRH)  kind_d = K_FRH;
    else if (id_q == ID_RDY)  kind_d = K_RDY;

    legal  = 1'b0;
    xfer   = len_q;
    base_d = '0;
    unique case (kind_d)
      K_REG: begin
        legal  = (req_data_i == 32'd0) && (len_q == 16'd4);
        base_d = 32'({id_q, 2'b00});
      end
      K_MEM: begin
        legal  = ({1'b0, req_data_i} + 33'(len_q)) <= 33'(MEM_BYTES);
        base_d = 32'(REG_BYTES) + req_data_i;
      end
      K_TOH: begin
        legal = is_rd && (req_data_i == 32'd0);
        xfer  = (len_q < avail) ? len_q : avail;
      end
      K_FRH: begin
        legal = is_wr && (req_data_i == 32'd0);
        xfer  = (len_q < space) ? len_q : space;
      end
      K_RDY:   legal = is_rd && (req_data_i == 32'd0) && (len_q == 16'd4);
      default: legal = 1'b0;
    endcase
    legal = legal && (is_rd || is_wr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_HDR;
      kind_q  <= K_NONE;
      cmd_q   <= '0;
      id_q    <= '0;
      len_q   <= '0;
      rem_q   <= '0;
      words_q <= '0;
      cnt_q   <= '0;
      cur_q   <= '0;
    end else begin
      unique case (state_q)
        S_HDR: if (req_fire) begin
          cmd_q   <= req_data_i[31:24];
          id_q    <= req_data_i[23:16];
          len_q   <= req_data_i[15:0];
          state_q <= S_OFF;
        end
        S_OFF: if (req_fire) begin
          kind_q  <= kind_d;
          cnt_q   <= legal ? 32'(xfer) : 32'hFFFF_FFFF;
          rem_q   <= legal ? xfer : 16'd0;
          cur_q   <= base_d;
          words_q <= is_wr ? words_d[15:0] : 16'd0;
          state_q <= (is_wr && words_d != 17'd0) ? S_WDAT : S_ACK0;
        end
        S_WDAT: if (req_fire) begin
          rem_q   <= rem_q - 16'(n4);
          cur_q   <= cur_q + 32'd4;
          words_q <= words_q - 16'd1;
          if (words_q == 16'd1) state_q <= S_ACK0;
        end
        S_ACK0: if (rsp_fire) state_q <= S_ACK1;
        S_ACK1: if (rsp_fire) state_q <= (is_rd && rem_q != 16'd0) ? S_RDAT : S_HDR;
        S_RDAT: if (rsp_fire) begin
          rem_q <= rem_q - 16'(n4);
          cur_q <= cur_q + 32'd4;
          if (rem_q <= 16'd4) state_q <= S_HDR;
        end
        default: state_q <= S_HDR;
      endcase
    end
  end

  assign code = is_rd ? ACK_RD : (is_wr ? ACK_WR : ACK_BAD);

  always_comb begin
    if (kind_q == K_TOH)      src = toh_rdata_i;
    else if (kind_q == K_RDY) src = {31'b0, mem_ready_i};
    else                      src = st_rdata_i;
    rsp_data_o = '0;
    unique case (state_q)
      S_ACK0: rsp_data_o = {code, id_q, 16'h0000};
      S_ACK1: rsp_data_o = cnt_q;
      S_RDAT: for (int k = 0; k < 4; k++)
                if (k < int'(n4)) rsp_data_o[8*k +: 8] = src[8*k +: 8];
      default: rsp_data_o = '0;
    endcase
  end

  always_comb begin
    st_we_o = '0;
    if (state_q == S_WDAT && req_fire && (kind_q == K_REG || kind_q == K_MEM))
      for (int k = 0; k < 4; k++) st_we_o[k] = (k < int'(n4));
  end

  assign st_addr_o    = cur_q;
  assign st_wdata_o   = req_data_i;
  assign frh_wdata_o  = req_data_i;
  assign frh_push_n_o = (state_q == S_WDAT && req_fire && kind_q == K_FRH) ? n4 : 3'd0;
  assign toh_pop_n_o  = (state_q == S_RDAT && rsp_fire && kind_q == K_TOH) ? n4 : 3'd0;
endmodule

// File: rtl/obj_access_responder.sv
module obj_access_responder
  import obj_resp_pkg::*;
#(
  parameter int         NUM_REGS   = 4,
  parameter int         MEM_BYTES  = 256,
  parameter int         FIFO_DEPTH = 16,
  parameter logic [7:0] ID_MEM     = 8'h10,
  parameter logic [7:0] ID_TOH     = 8'h20,
  parameter logic [7:0] ID_FRH     = 8'h21,
  parameter logic [7:0] ID_RDY     = 8'h30,
  localparam int MEM_AW = $clog2(MEM_BYTES / 4),
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic [31:0]             req_data_i,
  output logic                    rsp_valid_o,
  input  logic                    rsp_ready_i,
  output logic [31:0]             rsp_data_o,
  output logic [32*NUM_REGS-1:0]  reg_o,
  input  logic                    mem_ready_i,
  input  logic [MEM_AW-1:0]       hw_mem_addr_i,
  output logic [31:0]             hw_mem_rdata_o,
  input  logic                    toh_push_i,
  input  logic [7:0]              toh_data_i,
  output logic                    toh_full_o,
  input  logic                    frh_pop_i,
  output logic [7:0]              frh_data_o,
  output logic                    frh_empty_o
);
  logic [31:0]      st_addr, st_wdata, st_rdata;
  logic [3:0]       st_we;
  logic [CNT_W-1:0] toh_cnt, frh_cnt;
  logic [31:0]      toh_rdata, frh_wdata;
  logic [2:0]       toh_pop_n, frh_push_n;
  logic             toh_push_ok, frh_pop_ok;

  // a push into a full FIFO is kept when the host pops in the same cycle
  assign toh_push_ok = toh_push_i &&
                       ((toh_cnt != CNT_W'(FIFO_DEPTH)) || (toh_pop_n != 3'd0));
  assign frh_pop_ok  = frh_pop_i && (frh_cnt != '0);
  assign toh_full_o  = (toh_cnt == CNT_W'(FIFO_DEPTH));
  assign frh_empty_o = (frh_cnt == '0);

  ora_ctrl #(
    .NUM_REGS(NUM_REGS), .MEM_BYTES(MEM_BYTES), .FIFO_DEPTH(FIFO_DEPTH),
    .ID_MEM(ID_MEM), .ID_TOH(ID_TOH), .ID_FRH(ID_FRH), .ID_RDY(ID_RDY)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_data_i,
    .rsp_valid_o, .rsp_ready_i, .rsp_data_o,
    .st_addr_o(st_addr), .st_we_o(st_we), .st_wdata_o(st_wdata), .st_rdata_i(st_rdata),
    .toh_count_i(toh_cnt), .toh_rdata_i(toh_rdata), .toh_pop_n_o(toh_pop_n),
    .frh_count_i(frh_cnt), .frh_push_n_o(frh_push_n), .frh_wdata_o(frh_wdata),
    .mem_ready_i
  );

  ora_store #(.NUM_REGS(NUM_REGS), .MEM_BYTES(MEM_BYTES)) u_store (
    .clk_i, .rst_ni,
    .addr_i(st_addr), .we_i(st_we), .wdata_i(st_wdata), .rdata_o(st_rdata),
    .hw_addr_i(hw_mem_addr_i), .hw_rdata_o(hw_mem_rdata_o), .reg_o
  );

  ora_fifo #(.DEPTH(FIFO_DEPTH), .IN_LANES(1), .OUT_LANES(LANES)) u_toh (
    .clk_i, .rst_ni,
    .push_n_i(toh_push_ok), .wdata_i(toh_data_i),
    .pop_n_i(toh_pop_n), .rdata_o(toh_rdata), .count_o(toh_cnt)
  );

  ora_fifo #(.DEPTH(FIFO_DEPTH), .IN_LANES(LANES), .OUT_LANES(1)) u_frh (
    .clk_i, .rst_ni,
    .push_n_i(frh_push_n), .wdata_i(frh_wdata),
    .pop_n_i(frh_pop_ok), .rdata_o(frh_data_o), .count_o(frh_cnt)
  );
endmodule

// File: rtl/obj_access_responder_chk.sv
module obj_access_responder_chk #(
  parameter int NUM_REGS = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   req_valid_i,
  input logic                   req_ready_o,
  input logic                   rsp_valid_o,
  input logic                   rsp_ready_i,
  input logic [31:0]            rsp_data_o,
  input logic [32*NUM_REGS-1:0] reg_o,
  input logic                   toh_push_i,
  input logic                   toh_full_o,
  input logic                   frh_empty_o
);
  AST_ONE_AT_A_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o); // R11

  AST_RSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_data_o))); // R2

  AST_REG_ONLY_BY_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_ready_o) |=> $stable(reg_o)); // R3

  AST_TOH_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (toh_full_o && toh_push_i && !(rsp_valid_o && rsp_ready_i)) |=> toh_full_o); // R12

  AST_FRH_FILL_BY_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frh_empty_o && !(req_valid_i && req_ready_o)) |=> frh_empty_o); // R7
endmodule

bind obj_access_responder obj_access_responder_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i), .rsp_data_o(rsp_data_o),
  .reg_o(reg_o), .toh_push_i(toh_push_i), .toh_full_o(toh_full_o),
  .frh_empty_o(frh_empty_o)
);

// File: tb/obj_access_responder_bench.sv
module obj_access_responder_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, rsp_ready_i = 1'b0;
  logic [31:0] req_data_i = '0;
  logic        req_ready_o, rsp_valid_o;
  logic [31:0] rsp_data_o;
  logic [127:0] reg_o;
  logic        mem_ready_i = 1'b0;
  logic [5:0]  hw_mem_addr_i = '0;
  logic [31:0] hw_mem_rdata_o;
  logic        toh_push_i = 1'b0, frh_pop_i = 1'b0;
  logic [7:0]  toh_data_i = '0;
  logic        toh_full_o, frh_empty_o;
  logic [7:0]  frh_data_o;

  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  obj_access_responder u_obj_access_responder (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] w);
    req_valid_i = 1'b1;
    req_data_i  = w;
    while (!req_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic get(output logic [31:0] w);
    rsp_ready_i = 1'b1;
    while (!rsp_valid_o) @(negedge clk_i);
    w = rsp_data_o;
    @(negedge clk_i);
    rsp_ready_i = 1'b0;
  endtask

  task automatic hdr(input logic [7:0] cmd, input logic [7:0] id,
                     input logic [15:0] len, input logic [31:0] off);
    put({cmd, id, len});
    put(off);
  endtask

  task automatic ack(input string tag, input logic [7:0] code, input logic [7:0] id,
                     input logic [31:0] cnt);
    logic [31:0] w;
    get(w); chk({tag, " ack header"}, w, {code, id, 16'h0000});
    get(w); chk({tag, " ack count"}, w, cnt);
  endtask

  task automatic rdw(input string tag, input logic [31:0] exp);
    logic [31:0] w;
    get(w); chk(tag, w, exp);
  endtask

  task automatic hw_push(input logic [7:0] b);
    toh_push_i = 1'b1; toh_data_i = b;
    @(negedge clk_i);
    toh_push_i = 1'b0;
  endtask

  task automatic hw_pop();
    frh_pop_i = 1'b1;
    @(negedge clk_i);
    frh_pop_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R13 req_ready", 32'(req_ready_o), 32'd1);
    chk("R13 rsp_valid", 32'(rsp_valid_o), 32'd0);
    chk("R13 reg_o", reg_o[31:0] | reg_o[63:32] | reg_o[95:64] | reg_o[127:96], 32'd0);
    chk("R13 toh_full", 32'(toh_full_o), 32'd0);
    chk("R13 frh_empty", 32'(frh_empty_o), 32'd1);
  endtask

  task automatic t_reg();
    hdr(8'h02, 8'h01, 16'd4, 32'd0); put(32'hDEAD_BEEF);
    ack("R1 R3 reg write", 8'h82, 8'h01, 32'd4);
    chk("R3 reg_o[1]", reg_o[63:32], 32'hDEAD_BEEF);
    hdr(8'h01, 8'h01, 16'd4, 32'd0);
    ack("R10 reg read", 8'h81, 8'h01, 32'd4);
    rdw("R10 reg data", 32'hDEAD_BEEF);
  endtask

  task automatic t_reg_bad();
    hdr(8'h02, 8'h02, 16'd2, 32'd0); put(32'hFFFF_FFFF);
    ack("R3 short len", 8'h82, 8'h02, 32'hFFFF_FFFF);
    hdr(8'h02, 8'h02, 16'd4, 32'd4); put(32'h1234_5678);
    ack("R3 nonzero off", 8'h82, 8'h02, 32'hFFFF_FFFF);
    chk("R3 reg_o[2] unchanged", reg_o[95:64], 32'd0);
    hdr(8'h01, 8'h02, 16'd4, 32'd0);
    ack("R3 read back", 8'h81, 8'h02, 32'd4);
    rdw("R3 reg data", 32'd0);
  endtask

  task automatic t_mem();
    hdr(8'h02, 8'h10, 16'd6, 32'd5);
    put(32'h4433_2211); put(32'hAAAA_6655);
    ack("R4 mem write", 8'h82, 8'h10, 32'd6);
    hdr(8'h01, 8'h10, 16'd8, 32'd4);
    ack("R4 mem read", 8'h81, 8'h10, 32'd8);
    rdw("R1 R4 mem word0", 32'h3322_1100);
    rdw("R1 R4 mem word1", 32'h0066_5544);
    hdr(8'h01, 8'h10, 16'd3, 32'd5);
    ack("R2 partial read", 8'h81, 8'h10, 32'd3);
    rdw("R2 partial word zero-padded", 32'h0033_2211);
    hw_mem_addr_i = 6'd1; #1;
    chk("R4 hw port", hw_mem_rdata_o, 32'h3322_1100);
  endtask

  task automatic t_mem_oob();
    hdr(8'h02, 8'h10, 16'd4, 32'd254); put(32'h5555_5555);
    ack("R5 oob write", 8'h82, 8'h10, 32'hFFFF_FFFF);
    hdr(8'h01, 8'h10, 16'd4, 32'd252);
    ack("R5 edge read", 8'h81, 8'h10, 32'd4);
    rdw("R5 edge data unchanged", 32'd0);
    hdr(8'h01, 8'h10, 16'd0, 32'd256);
    ack("R5 zero len at end", 8'h81, 8'h10, 32'd0);
    hdr(8'h01, 8'h10, 16'd1, 32'd256);
    ack("R5 oob read", 8'h81, 8'h10, 32'hFFFF_FFFF);
  endtask

  task automatic t_dir();
    hdr(8'h01, 8'h21, 16'd4, 32'd0);
    ack("R8 read write-only fifo", 8'h81, 8'h21, 32'hFFFF_FFFF);
    hdr(8'h02, 8'h20, 16'd4, 32'd0); put(32'h0102_0304);
    ack("R8 write read-only fifo", 8'h82, 8'h20, 32'hFFFF_FFFF);
    hdr(8'h01, 8'h55, 16'd4, 32'd0);
    ack("R8 unknown id", 8'h81, 8'h55, 32'hFFFF_FFFF);
    hdr(8'h01, 8'h20, 16'd4, 32'd4);
    ack("R8 fifo offset", 8'h81, 8'h20, 32'hFFFF_FFFF);
    hdr(8'h02, 8'h30, 16'd4, 32'd0); put(32'h0000_0001);
    ack("R8 write status", 8'h82, 8'h30, 32'hFFFF_FFFF);
    hdr(8'h07, 8'h55, 16'd8, 32'd0);
    ack("R2 unknown cmd", 8'hFF, 8'h55, 32'hFFFF_FFFF);
    hdr(8'h01, 8'h01, 16'd4, 32'd0);
    ack("R2 stream aligned", 8'h81, 8'h01, 32'd4);
    rdw("R2 stream aligned data", 32'hDEAD_BEEF);
  endtask

  task automatic t_toh();
    hdr(8'h01, 8'h20, 16'd4, 32'd0);
    ack("R6 empty read", 8'h81, 8'h20, 32'd0);
    chk("R6 no data words", 32'(rsp_valid_o), 32'd0);
    for (int i = 0; i < 5; i++) hw_push(8'hA0 + 8'(i));
    hdr(8'h01, 8'h20, 16'd8, 32'd0);
    ack("R6 short read", 8'h81, 8'h20, 32'd5);
    rdw("R6 word0", 32'hA3A2_A1A0);
    rdw("R6 word1", 32'h0000_00A4);
  endtask

  task automatic t_concurrent();
    for (int i = 0; i < 16; i++) hw_push(8'(i));
    chk("R12 full", 32'(toh_full_o), 32'd1);
    hw_push(8'hEE);
    chk("R12 still full", 32'(toh_full_o), 32'd1);
    toh_push_i = 1'b1; toh_data_i = 8'h77;
    hdr(8'h01, 8'h20, 16'd4, 32'd0);
    ack("R12 read while pushing", 8'h81, 8'h20, 32'd4);
    rdw("R12 popped word", 32'h0302_0100);
    toh_push_i = 1'b0;
    chk("R12 not full", 32'(toh_full_o), 32'd0);
    hdr(8'h01, 8'h20, 16'd16, 32'd0);
    ack("R12 drain", 8'h81, 8'h20, 32'd13);
    rdw("R12 w0", 32'h0706_0504);
    rdw("R12 w1", 32'h0B0A_0908);
    rdw("R12 w2", 32'h0F0E_0D0C);
    rdw("R12 same-cycle push kept", 32'h0000_0077);
  endtask

  task automatic t_frh();
    hdr(8'h02, 8'h21, 16'd6, 32'd0);
    put(32'h1413_1211); put(32'hBBBB_1615);
    ack("R7 fifo write", 8'h82, 8'h21, 32'd6);
    chk("R7 not empty", 32'(frh_empty_o), 32'd0);
    for (int i = 0; i < 6; i++) begin
      chk("R7 pop order", 32'(frh_data_o), 32'(8'h11 + 8'(i)));
      hw_pop();
    end
    chk("R7 empty", 32'(frh_empty_o), 32'd1);
    hdr(8'h02, 8'h21, 16'd20, 32'd0);
    for (int w = 0; w < 5; w++)
      put({8'h40 + 8'(4*w+3), 8'h40 + 8'(4*w+2), 8'h40 + 8'(4*w+1), 8'h40 + 8'(4*w)});
    ack("R7 overfill", 8'h82, 8'h21, 32'd16);
    for (int i = 0; i < 16; i++) begin
      chk("R7 overfill order", 32'(frh_data_o), 32'(8'h40 + 8'(i)));
      hw_pop();
    end
    chk("R7 empty after 16", 32'(frh_empty_o), 32'd1);
  endtask

  task automatic t_rdy();
    mem_ready_i = 1'b0;
    hdr(8'h01, 8'h30, 16'd4, 32'd0);
    ack("R9 status read", 8'h81, 8'h30, 32'd4);
    rdw("R9 not ready", 32'd0);
    mem_ready_i = 1'b1;
    hdr(8'h01, 8'h30, 16'd4, 32'd0);
    ack("R10 status reread", 8'h81, 8'h30, 32'd4);
    rdw("R10 ready now", 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_reg();
    t_reg_bad();
    t_mem();
    t_mem_oob();
    t_dir();
    t_toh();
    t_concurrent();
    t_frh();
    t_rdy();
    repeat (2) @(negedge clk_i);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule